// File: doc/BRIEF.md
# Cycle-Steal DMA Engine

This block moves data on behalf of a processor without occupying it for a whole block copy. It holds several independent channels. Each channel keeps a memory pointer, a fixed peripheral address, a transfer counter and a small control word. Once armed, a channel performs single transfers, each one a bus read from the memory pointer followed by a bus write of the same data to the peripheral address. The engine takes the bus for one transfer at a time and then releases it, so other masters run between transfers. Three things can start a transfer: a one-cycle software or internal trigger pulse, or the level on an external request pin that is synchronised inside the block.

The bus side is a plain master port. The engine holds `bus_req` with a steady address and direction until the outside arbiter returns `bus_gnt`, and each granted cycle completes one operation. A small state machine sequences the transfers through three states. `S_ARB` picks the highest-priority channel with work. `S_READ` performs the memory read. `S_WRITE` performs the peripheral write.

The transitions are as follows. `S_ARB` goes to `S_WRITE` if the chosen channel already holds read data, and to `S_READ` otherwise. It stays in `S_ARB` when no channel has work. `S_READ` and `S_WRITE` each return to `S_ARB` on a grant. Because the state machine passes through `S_ARB` between the read and the write, a higher-priority channel can slip a whole transfer into that gap. A lower-priority channel cannot.

Top module: `dma_ctl`

## Requirements
- R1: After reset, `bus_req`, `tend` and every `irq` bit are 0, every channel is disabled, and each address register reads 0.
- R2: A configuration write (`cfg_we`=1) to channel `cfg_ch` loads a register chosen by `cfg_sel`: 0 loads the memory pointer and its reload copy, 1 loads the peripheral address, 2 loads the count and its reload copy, and 3 loads control. The control bits are [0] enable, [1] interrupt enable, [2] decrement, [3] two-byte step, [4] repeat and [5] external start.
- R3: A transfer is a read at the memory pointer, then a write to the peripheral address carrying the data read. While `bus_req`=1 and `bus_gnt`=0, the values of `bus_req`, `bus_addr` and `bus_we` hold.
- R4: After each read, the memory pointer moves by 1, or by 2 when the two-byte step bit is set. It moves up, or down when the decrement bit is set. Arithmetic wraps modulo 2^AW.
- R5: With external start clear, a trigger pulse sampled at clock edge E1 on an enabled channel produces exactly one transfer. Its read request is first visible after edge E2.
- R6: With external start set, the request pin passes through two synchronising flops. A pin high before edge E1 gives the first read request after edge E3. Transfers repeat while the pin stays high and the channel is enabled.
- R7: Each write decrements the count. The write that takes the count from 1 to 0 clears the enable bit when repeat is off. A count of 0 means 2^CW transfers.
- R8: With repeat on, that write instead reloads the pointer and count from their last written values, and the channel stays enabled.
- R9: `tend` is 1 during the write that takes the count to zero, and only when the channel uses external start. It is never 1 outside a write.
- R10: Channel 0 has the highest priority, and priority falls as the index rises. Channels with work at the same time are served lowest index first.
- R11: Between the read and the write of a channel, a pending channel of higher priority runs its complete transfer first. A pending channel of lower priority waits until that write finishes.
- R12: `irq[c]` equals interrupt enable AND NOT enable for channel c. It therefore rises at the end of a non-repeating run and also when software clears the enable bit.
- R13: `rd_addr` shows the memory pointer of channel `rd_ch`. Reading it has no effect on any transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | $clog2(NCH) | Channel selected for the configuration write |
| cfg_sel | input | 2 | Register selected for the configuration write |
| cfg_wdata | input | AW | Configuration write data |
| sw_trig | input | NCH | One-cycle trigger pulses, one per channel |
| ext_req | input | NCH | Asynchronous external request levels |
| rd_ch | input | $clog2(NCH) | Channel whose pointer is shown on rd_addr |
| rd_addr | output | AW | Current memory pointer of channel rd_ch |
| bus_req | output | 1 | Bus request, held until granted |
| bus_we | output | 1 | 1 for a write operation, 0 for a read |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid in the granted read cycle |
| bus_gnt | input | 1 | Grant, which completes the current operation |
| tend | output | 1 | Terminal-count write of an externally started channel |
| irq | output | NCH | End-of-transfer interrupt per channel |

## Verification
The bench builds the engine with three channels, 16-bit addresses and data, and an 8-bit count. Three channels give a middle channel that can both preempt a lower one and be preempted by a higher one. Because three is not a power of two, one arbiter slot is padded and must never be chosen. The 16-bit pointer lets random start addresses wrap through zero in both directions. Random counts of 1 to 6, together with a randomly withheld grant, reach the terminal count many times in each round. Directed cases pin down the trigger and synchroniser latencies, the preemption order in both directions, repeat reload and the software-clear interrupt.

// File: rtl/dma_pkg.sv
package dma_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        S_ARB   = 2'd0,
        S_READ  = 2'd1,
        S_WRITE = 2'd2
    } dma_state_t;

    // Per-channel control word, bit 0 = enable
    typedef struct packed {
        logic ext;   // [5] external start
        logic rpt;   // [4] repeat
        logic wide;  // [3] two-byte step
        logic dir;   // [2] decrement
        logic ie;    // [1] interrupt enable
        logic en;    // [0] enable
    } dma_ctrl_t;

    localparam int CTRL_W = 6;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_IO   = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

endpackage

// File: rtl/dma_sync.sv
module dma_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int STAGES = 2;

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];

    for (genvar b = 0; b < W; b++) begin : g_chk
        // R6
        sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dout[b]) |-> $past(din[b], 2));
    end

endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Fixed priority: lowest index wins
    always_comb begin
        idx = '0;
        any = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          trig,
    input  logic          ext_lvl,
    input  logic          rd_fire,
    input  logic          wr_fire,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] mar,
    output logic [AW-1:0] ioar,
    output logic [DW-1:0] hold,
    output logic          req,
    output logic          rd_done,
    output logic          tc,
    output logic          ext_mode,
    output logic          irq
);
    dma_ctrl_t     ctrl;
    logic [AW-1:0] mar0;
    logic [CW-1:0] cnt, cnt0;
    logic          pend;
    logic [AW-1:0] step, mar_adv;

    assign step    = ctrl.wide ? AW'(2) : AW'(1);
    assign mar_adv = ctrl.dir ? (mar - step) : (mar + step);
    assign tc      = (cnt == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mar     <= '0;
            mar0    <= '0;
            ioar    <= '0;
            cnt     <= '0;
            cnt0    <= '0;
            ctrl    <= '0;
            pend    <= 1'b0;
            rd_done <= 1'b0;
            hold    <= '0;
        end else begin
            if (rd_fire) begin
                pend    <= 1'b0;
                rd_done <= 1'b1;
                hold    <= rdata;
                mar     <= mar_adv;
            end
            if (wr_fire) begin
                rd_done <= 1'b0;
                if (tc && ctrl.rpt) begin
                    mar <= mar0;
                    cnt <= cnt0;
                end else begin
                    cnt <= cnt - CW'(1);
                    if (tc) ctrl.en <= 1'b0;
                end
            end
            if (trig && ctrl.en && !ctrl.ext) pend <= 1'b1;
            if (wr_en) begin
                unique case (wr_sel)
                    SEL_ADDR: begin
                        mar  <= wr_data;
                        mar0 <= wr_data;
                    end
                    SEL_IO:   ioar <= wr_data;
                    SEL_CNT: begin
                        cnt  <= wr_data[CW-1:0];
                        cnt0 <= wr_data[CW-1:0];
                    end
                    SEL_CTRL: ctrl <= dma_ctrl_t'(wr_data[CTRL_W-1:0]);
                endcase
            end
        end
    end

    assign req      = ctrl.en && (rd_done || (ctrl.ext ? ext_lvl : pend));
    assign ext_mode = ctrl.ext;
    assign irq      = ctrl.ie && !ctrl.en;

    // R7
    count_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && tc && !ctrl.rpt && !wr_en) |=> !ctrl.en);

    // R8
    rpt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && tc && ctrl.rpt && !wr_en) |=> (cnt == cnt0) && (mar == mar0) && ctrl.en);

endmodule

// File: rtl/dma_ctl.sv
module dma_ctl
    import dma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int CW  = 8,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [1:0]     cfg_sel,
    input  logic [AW-1:0]  cfg_wdata,
    input  logic [NCH-1:0] sw_trig,
    input  logic [NCH-1:0] ext_req,
    input  logic [CHW-1:0] rd_ch,
    output logic [AW-1:0]  rd_addr,
    output logic           bus_req,
    output logic           bus_we,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    input  logic           bus_gnt,
    output logic           tend,
    output logic [NCH-1:0] irq
);
    localparam int NSLOT = 1 << CHW;

    dma_state_t       state, nxt;
    logic [CHW-1:0]   cur, pick;
    logic             any;
    logic             rd_fire, wr_fire;
    logic [NCH-1:0]   ext_s;

    logic [AW-1:0]    mar_a  [NSLOT];
    logic [AW-1:0]    io_a   [NSLOT];
    logic [DW-1:0]    hold_a [NSLOT];
    logic [NSLOT-1:0] req_v, done_v, tc_v, ext_v;

    dma_sync #(.W(NCH)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_req),
        .dout (ext_s)
    );

    for (genvar c = 0; c < NSLOT; c++) begin : g_ch
        if (c < NCH) begin : g_real
            dma_chan #(.AW(AW), .DW(DW), .CW(CW)) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (cfg_we && (cfg_ch == CHW'(c))),
                .wr_sel  (cfg_sel),
                .wr_data (cfg_wdata),
                .trig    (sw_trig[c]),
                .ext_lvl (ext_s[c]),
                .rd_fire (rd_fire && (cur == CHW'(c))),
                .wr_fire (wr_fire && (cur == CHW'(c))),
                .rdata   (bus_rdata),
                .mar     (mar_a[c]),
                .ioar    (io_a[c]),
                .hold    (hold_a[c]),
                .req     (req_v[c]),
                .rd_done (done_v[c]),
                .tc      (tc_v[c]),
                .ext_mode(ext_v[c]),
                .irq     (irq[c])
            );
        end else begin : g_pad
            assign mar_a[c]  = '0;
            assign io_a[c]   = '0;
            assign hold_a[c] = '0;
            assign req_v[c]  = 1'b0;
            assign done_v[c] = 1'b0;
            assign tc_v[c]   = 1'b0;
            assign ext_v[c]  = 1'b0;
        end
    end

    dma_arb #(.N(NSLOT)) u_arb (
        .req(req_v),
        .idx(pick),
        .any(any)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_ARB;
            cur   <= '0;
        end else begin
            state <= nxt;
            if (state == S_ARB && any) cur <= pick;
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_ARB:   if (any) nxt = done_v[pick] ? S_WRITE : S_READ;
            S_READ:  if (bus_gnt) nxt = S_ARB;
            S_WRITE: if (bus_gnt) nxt = S_ARB;
            default: nxt = S_ARB;
        endcase
    end

    // Outputs
    always_comb begin
        bus_req   = (state == S_READ) || (state == S_WRITE);
        bus_we    = (state == S_WRITE);
        bus_addr  = bus_we ? io_a[cur] : mar_a[cur];
        bus_wdata = hold_a[cur];
        rd_fire   = (state == S_READ) && bus_gnt;
        wr_fire   = (state == S_WRITE) && bus_gnt;
        tend      = (state == S_WRITE) && tc_v[cur] && ext_v[cur];
    end

    assign rd_addr = mar_a[rd_ch];

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req && $stable(bus_addr) && $stable(bus_we));

    // R9
    tend_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tend |-> (bus_req && bus_we));

    // R10
    top_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ARB && req_v[0]) |=> (cur == '0) && (state != S_ARB));

    // R11
    write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WRITE) |-> done_v[cur]);

endmodule

// File: tb/dma_ctl_bench.sv
`timescale 1ns/1ps
module dma_ctl_bench;
    localparam int NCH = 3;
    localparam int AW  = 16;
    localparam int DW  = 16;
    localparam int CW  = 8;
    localparam int CHW = 2;
    localparam logic [15:0] IOBASE = 16'hF000;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           cfg_we;
    logic [CHW-1:0] cfg_ch;
    logic [1:0]     cfg_sel;
    logic [AW-1:0]  cfg_wdata;
    logic [NCH-1:0] sw_trig;
    logic [NCH-1:0] ext_req;
    logic [CHW-1:0] rd_ch;
    logic [AW-1:0]  rd_addr;
    logic           bus_req, bus_we, bus_gnt, tend;
    logic [AW-1:0]  bus_addr;
    logic [DW-1:0]  bus_wdata, bus_rdata;
    logic [NCH-1:0] irq;

    always #2.5 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    bit rgnt = 1'b0;

    logic [15:0] sb_m0 [NCH];
    bit          sb_dir [NCH], sb_wide [NCH], sb_rpt [NCH], sb_ext [NCH];
    int          sb_n [NCH];
    int          wcount [NCH];
    logic [15:0] op_addr [64];
    bit          op_we [64];
    int          op_n = 0;

    function automatic logic [15:0] memfun(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] exp_addr(input int c, input int k);
        int kk;
        logic [15:0] off;
        kk  = sb_rpt[c] ? (k % sb_n[c]) : k;
        off = 16'(kk * (sb_wide[c] ? 2 : 1));
        return sb_dir[c] ? (sb_m0[c] - off) : (sb_m0[c] + off);
    endfunction

    assign bus_rdata = memfun(bus_addr);

    dma_ctl #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) u_dma_ctl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .sw_trig(sw_trig),
        .ext_req(ext_req), .rd_ch(rd_ch), .rd_addr(rd_addr),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_gnt(bus_gnt),
        .tend(tend), .irq(irq)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // Grant driver
    always begin
        @(negedge clk);
        #1;
        bus_gnt = rgnt ? (($urandom % 4) != 0) : 1'b1;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "watchdog expired", cyc, 150000);
            summary();
            $finish;
        end
    end

    // Bus monitor and scoreboard
    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            if (bus_req && !bus_we) check(tend == 1'b0, "R9 tend outside write", 32'(tend), 0);
            if (bus_req && bus_gnt) begin
                if (op_n < 64) begin
                    op_addr[op_n] = bus_addr;
                    op_we[op_n]   = bus_we;
                    op_n++;
                end
                if (bus_we) begin
                    int c, kk;
                    logic [15:0] ea;
                    bit et;
                    c = int'((bus_addr - IOBASE) >> 4);
                    if (c >= 0 && c < NCH && bus_addr[3:0] == 4'h0) begin
                        ea = exp_addr(c, wcount[c]);
                        kk = sb_rpt[c] ? (wcount[c] % sb_n[c]) : wcount[c];
                        et = sb_ext[c] && (kk == sb_n[c] - 1);
                        check(bus_wdata == memfun(ea), "R3 write data", 32'(bus_wdata), 32'(memfun(ea)));
                        check(tend == et, "R9 tend at terminal write", 32'(tend), 32'(et));
                        wcount[c]++;
                    end else begin
                        check(1'b0, "R3 write address", 32'(bus_addr), 32'(IOBASE));
                    end
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_we = 1'b0; cfg_ch = '0; cfg_sel = '0; cfg_wdata = '0;
        sw_trig = '0; ext_req = '0; rd_ch = '0; rgnt = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            wcount[c] = 0; sb_n[c] = 1; sb_m0[c] = '0;
            sb_dir[c] = 0; sb_wide[c] = 0; sb_rpt[c] = 0; sb_ext[c] = 0;
        end
        repeat (3) tick();
        rst_n = 1'b1;
        op_n = 0;
        tick();
    endtask

    task automatic cfg_wr(input int c, input logic [1:0] sel, input logic [15:0] d);
        cfg_we = 1'b1; cfg_ch = CHW'(c); cfg_sel = sel; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic setup_ch(input int c, input logic [15:0] m0, input bit dir, input bit wide,
                            input int n, input bit rpt, input bit ext, input bit ie);
        sb_m0[c] = m0; sb_dir[c] = dir; sb_wide[c] = wide; sb_n[c] = n;
        sb_rpt[c] = rpt; sb_ext[c] = ext; wcount[c] = 0;
        cfg_wr(c, 2'd0, m0);
        cfg_wr(c, 2'd1, IOBASE + 16'(c * 16));
        cfg_wr(c, 2'd2, 16'(n));
        cfg_wr(c, 2'd3, {10'd0, ext, rpt, wide, dir, ie, 1'b1});
        rd_ch = CHW'(c);
        #0.1;
        check(rd_addr == m0, "R2 pointer load", 32'(rd_addr), 32'(m0));
    endtask

    task automatic pulse(input logic [NCH-1:0] m);
        sw_trig = m;
        tick();
        sw_trig = '0;
    endtask

    task automatic wait_writes(input int c, input int target);
        int t;
        t = 0;
        while (wcount[c] < target && t < 1000) begin tick(); t++; end
        check(wcount[c] >= target, "R5 transfer completes", 32'(wcount[c]), 32'(target));
    endtask

    task automatic wait_irq(input logic [NCH-1:0] m);
        int t;
        t = 0;
        while ((irq & m) != m && t < 2000) begin tick(); t++; end
        check((irq & m) == m, "R12 end interrupt", 32'(irq), 32'(m));
    endtask

    task automatic check_op(input int i, input logic [15:0] a, input bit we, input string rq);
        check(op_addr[i] == a && op_we[i] == we, rq, {15'd0, op_we[i], op_addr[i]}, {15'd0, we, a});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        bus_gnt = 1'b1;

        // R1 reset state
        do_reset();
        check(bus_req == 1'b0, "R1 bus_req after reset", 32'(bus_req), 0);
        check(tend == 1'b0, "R1 tend after reset", 32'(tend), 0);
        check(irq == '0, "R1 irq after reset", 32'(irq), 0);
        check(rd_addr == '0, "R1 pointer after reset", 32'(rd_addr), 0);

        // R5 software trigger latency and single transfer
        setup_ch(0, 16'h1000, 1'b0, 1'b0, 2, 1'b0, 1'b0, 1'b1);
        sw_trig = 3'b001;
        tick();
        sw_trig = '0;
        check(bus_req == 1'b0, "R5 no request after E1", 32'(bus_req), 0);
        tick();
        check(bus_req && !bus_we && bus_addr == 16'h1000, "R5 read after E2",
              {bus_req, bus_we, bus_addr}, {1'b1, 1'b0, 16'h1000});
        repeat (10) tick();
        check(wcount[0] == 1, "R5 exactly one transfer", 32'(wcount[0]), 1);
        rd_ch = 2'd0;
        #0.1;
        check(rd_addr == 16'h1001, "R4 increment by one", 32'(rd_addr), 32'h1001);
        check(irq[0] == 1'b0, "R12 no irq while enabled", 32'(irq[0]), 0);
        pulse(3'b001);
        wait_writes(0, 2);
        wait_irq(3'b001);
        check(wcount[0] == 2, "R7 count stops run", 32'(wcount[0]), 2);

        // R6 external request latency
        do_reset();
        setup_ch(1, 16'h2000, 1'b1, 1'b1, 4, 1'b0, 1'b1, 1'b1);
        ext_req = 3'b010;
        tick();
        check(bus_req == 1'b0, "R6 no request after E1", 32'(bus_req), 0);
        tick();
        check(bus_req == 1'b0, "R6 no request after E2", 32'(bus_req), 0);
        tick();
        check(bus_req == 1'b1 && bus_addr == 16'h2000, "R6 read after E3",
              {bus_req, bus_addr}, {1'b1, 16'h2000});
        wait_irq(3'b010);
        ext_req = '0;
        check(wcount[1] == 4, "R7 external run length", 32'(wcount[1]), 4);
        rd_ch = 2'd1;
        #0.1;
        check(rd_addr == 16'h1FF8, "R4 decrement by two", 32'(rd_addr), 32'h1FF8);

        // R10 fixed priority
        do_reset();
        setup_ch(0, 16'h4000, 1'b0, 1'b0, 1, 1'b0, 1'b0, 1'b1);
        setup_ch(1, 16'h5000, 1'b0, 1'b0, 1, 1'b0, 1'b0, 1'b1);
        setup_ch(2, 16'h6000, 1'b0, 1'b0, 1, 1'b0, 1'b0, 1'b1);
        op_n = 0;
        pulse(3'b111);
        wait_irq(3'b111);
        check(op_n == 6, "R10 operation count", 32'(op_n), 6);
        for (int c = 0; c < NCH; c++) begin
            check_op(2 * c, 16'h4000 + 16'(c * 16'h1000), 1'b0, "R10 read order");
            check_op(2 * c + 1, IOBASE + 16'(c * 16), 1'b1, "R10 write order");
        end

        // R11 higher priority slips in between read and write
        do_reset();
        setup_ch(0, 16'h7000, 1'b0, 1'b0, 2, 1'b0, 1'b0, 1'b1);
        setup_ch(1, 16'h8000, 1'b0, 1'b1, 2, 1'b0, 1'b0, 1'b1);
        op_n = 0;
        pulse(3'b010);
        for (int t = 0; t < 20 && !(bus_req && !bus_we); t++) tick();
        pulse(3'b001);
        wait_writes(0, 1);
        wait_writes(1, 1);
        check_op(0, 16'h8000, 1'b0, "R11 low channel read");
        check_op(1, 16'h7000, 1'b0, "R11 high channel preempts read");
        check_op(2, IOBASE, 1'b1, "R11 high channel write");
        check_op(3, IOBASE + 16'h10, 1'b1, "R11 low channel resumes write");
        // lower priority must wait
        repeat (3) tick();
        op_n = 0;
        pulse(3'b001);
        for (int t = 0; t < 20 && !(bus_req && !bus_we); t++) tick();
        pulse(3'b010);
        wait_writes(1, 2);
        check_op(0, 16'h7001, 1'b0, "R11 high channel read");
        check_op(1, IOBASE, 1'b1, "R11 lower waits for write");
        check_op(2, 16'h8002, 1'b0, "R11 lower read after");
        check_op(3, IOBASE + 16'h10, 1'b1, "R11 lower write after");

        // R8 repeat mode with software trigger, tend stays low
        do_reset();
        rgnt = 1'b1;
        setup_ch(1, 16'h3000, 1'b0, 1'b1, 3, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 7; i++) begin
            pulse(3'b010);
            wait_writes(1, i + 1);
        end
        repeat (4) tick();
        check(irq[1] == 1'b0, "R8 channel stays enabled", 32'(irq[1]), 0);
        rd_ch = 2'd1;
        #0.1;
        check(rd_addr == exp_addr(1, 7), "R8 pointer reload", 32'(rd_addr), 32'(exp_addr(1, 7)));

        // R12 software clear of enable
        cfg_wr(1, 2'd3, 16'h0002);
        check(irq[1] == 1'b1, "R12 irq on software clear", 32'(irq[1]), 1);
        cfg_wr(1, 2'd3, 16'h0000);
        check(irq[1] == 1'b0, "R12 irq drops with ie", 32'(irq[1]), 0);
        check(irq[2] == 1'b0, "R12 idle channel quiet", 32'(irq[2]), 0);

        // Random rounds: external start, random grant, pointer reads
        for (int r = 0; r < 6; r++) begin
            int t;
            do_reset();
            rgnt = 1'b1;
            for (int c = 0; c < NCH; c++) begin
                setup_ch(c, 16'($urandom), 1'($urandom), 1'($urandom),
                         1 + int'($urandom % 6), 1'b0, 1'b1, 1'b1);
            end
            ext_req = '1;
            t = 0;
            while (irq != '1 && t < 3000) begin
                rd_ch = CHW'($urandom % NCH);
                tick();
                t++;
            end
            ext_req = '0;
            check(irq == '1, "R7 all channels finish", 32'(irq), 32'h7);
            for (int c = 0; c < NCH; c++) begin
                check(wcount[c] == sb_n[c], "R7 random run length", 32'(wcount[c]), 32'(sb_n[c]));
                rd_ch = CHW'(c);
                #0.1;
                check(rd_addr == exp_addr(c, sb_n[c]), "R13 pointer after reads",
                      32'(rd_addr), 32'(exp_addr(c, sb_n[c])));
            end
        end

        summary();
        $finish;
    end

endmodule